// File: doc/BRIEF.md
# Double-Speed UART Receive Front End

This block recovers bytes from an asynchronous serial line when the line is sampled eight times per bit. A 12-bit divisor sets how often a sample is taken. While the line is idle the receiver waits for a low sample, treats it as the first sample of a start bit, and confirms the start bit by majority over the fourth, fifth and sixth samples of that bit window. A start bit that fails the vote is dropped as a glitch and the receiver goes back to watching for an edge.

After a good start bit the receiver votes on each of eight data bits, least significant first, and then on the stop bit, each at window positions four to six. Each finished frame presents its byte with a one-clock strobe and a flag that tells whether the stop bit came out low. The strobe is issued at the stop bit's decision sample, so a following start bit can be taken on the next low sample.

Top module: `uart_rx_x8`

## Requirements
- R1: A sample is taken once every divisor+1 clock cycles (every clock for divisor 0). With divisor 0 and the input low from a given clock edge onward, `rx_valid` is asserted on the 80th rising edge counted from that edge (two synchronizer stages plus 78 samples).
- R2: `rx_in` passes through two flops whose reset value is high; while hunting, a single low sample starts start-bit qualification and counts as sample 1.
- R3: If two or more of samples 4, 5 and 6 of the start window are high, no byte is produced and the receiver resumes hunting.
- R4: A start bit with at most one high sample among positions 4 to 6 is accepted, even when other samples of that window are high.
- R5: Each data bit is the majority of samples 4, 5 and 6 of its 8-sample window; bits arrive least significant first and `rx_data[0]` holds the first one.
- R6: The stop bit is voted the same way; `frame_err` is 1 when it comes out low and 0 when high, the byte is delivered either way, and `frame_err` and `rx_data` only change when `rx_valid` is high.
- R7: `rx_valid` is high for exactly one clock cycle per accepted frame.
- R8: After the stop-bit decision the receiver is hunting; a start bit beginning right after the sixth stop sample is accepted.
- R9: Synchronous reset `rst` clears `rx_data`, `rx_valid` and `frame_err`, abandons any frame in progress and returns to hunting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| divisor | input | 12 | Sample period minus one, in clock cycles |
| rx_in | input | 1 | Asynchronous serial input, idle high |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for a new byte |
| frame_err | output | 1 | Stop bit of the last byte was voted low |

## Verification
The hardest situations to reach are the ones that hinge on which exact sample positions carry a glitch: a start bit that is rejected by the vote, one that survives a single high sample, and a data bit with a one-sample inversion. With divisor 0 every clock is a sample and the synchronizer delay is fixed, so the bench drives the line one sample per clock and can place a glitch at a chosen window position. The back-to-back case shortens the stop bit to six samples so the next start falls on the first sample after the decision.

// File: rtl/uart_rx_x8_pkg.sv
package uart_rx_x8_pkg;
   typedef enum logic [1:0] {
      ST_HUNT  = 2'd0,
      ST_START = 2'd1,
      ST_DATA  = 2'd2,
      ST_STOP  = 2'd3
   } rx_state_e;
endpackage

// File: rtl/rx_sync_chain.sv
module rx_sync_chain #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d_in,
   output logic d_out
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) chain[0] <= 1'b1;
               else     chain[0] <= d_in;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) chain[i] <= 1'b1;
               else     chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign d_out = chain[STAGES-1];
endmodule

// File: rtl/rx_baud_tick.sv
module rx_baud_tick #(
   parameter int DIV_W = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [DIV_W-1:0] divisor,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   // >= keeps the counter wrapping when the divisor is lowered mid-count
   assign tick = (cnt >= divisor);

   always_ff @(posedge clk) begin
      if (rst)       cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/rx_frame_sampler.sv
module rx_frame_sampler
   import uart_rx_x8_pkg::*;
#(
   parameter int DATA_BITS = 8,
   parameter int OVS       = 8,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 tick,
   input  logic                 line,
   output rx_state_e            state_o,
   output logic [DATA_BITS-1:0] data_o,
   output logic                 valid_o,
   output logic                 err_o
);
   localparam int POS_W   = $clog2(OVS + 1);
   localparam int BCNT_W  = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
   localparam int VOTE_LO = OVS / 2;
   localparam int VOTE_HI = OVS / 2 + 2;

   rx_state_e            state;
   logic [POS_W-1:0]     pos, pos_nxt;
   logic [1:0]           hi_cnt, votes;
   logic                 maj_hi, in_vote, decide;
   logic [BCNT_W-1:0]    bit_cnt;
   logic [DATA_BITS-1:0] shreg, shreg_nxt;

   always_comb begin
      pos_nxt = (pos == POS_W'(OVS)) ? POS_W'(1) : pos + 1'b1;
      in_vote = (pos_nxt >= POS_W'(VOTE_LO)) && (pos_nxt < POS_W'(VOTE_HI));
      decide  = (pos_nxt == POS_W'(VOTE_HI));
      votes   = hi_cnt + {1'b0, line};
      maj_hi  = votes[1];
   end

   generate
      if (LSB_FIRST) begin : g_lsb_first
         assign shreg_nxt = {maj_hi, shreg[DATA_BITS-1:1]};
      end else begin : g_msb_first
         assign shreg_nxt = {shreg[DATA_BITS-2:0], maj_hi};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         state   <= ST_HUNT;
         pos     <= POS_W'(1);
         hi_cnt  <= '0;
         bit_cnt <= '0;
         shreg   <= '0;
         data_o  <= '0;
         valid_o <= 1'b0;
         err_o   <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (tick) begin
            if (state == ST_HUNT) begin
               if (!line) begin
                  state  <= ST_START;
                  pos    <= POS_W'(1);
                  hi_cnt <= '0;
               end
            end else begin
               pos <= pos_nxt;
               if (in_vote) hi_cnt <= votes;
               if (decide) begin
                  hi_cnt <= '0;
                  case (state)
                     ST_START: begin
                        if (maj_hi) state <= ST_HUNT;
                        else begin
                           state   <= ST_DATA;
                           bit_cnt <= '0;
                        end
                     end
                     ST_DATA: begin
                        shreg <= shreg_nxt;
                        if (bit_cnt == BCNT_W'(DATA_BITS - 1)) state <= ST_STOP;
                        else bit_cnt <= bit_cnt + 1'b1;
                     end
                     ST_STOP: begin
                        data_o  <= shreg;
                        err_o   <= ~maj_hi;
                        valid_o <= 1'b1;
                        state   <= ST_HUNT;
                     end
                     default: state <= ST_HUNT;
                  endcase
               end
            end
         end
      end
   end

   assign state_o = state;
endmodule

// File: rtl/uart_rx_x8.sv
module uart_rx_x8
   import uart_rx_x8_pkg::*;
#(
   parameter int DIV_W       = 12,
   parameter int DATA_BITS   = 8,
   parameter int OVS         = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit LSB_FIRST   = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [DIV_W-1:0]     divisor,
   input  logic                 rx_in,
   output logic [DATA_BITS-1:0] rx_data,
   output logic                 rx_valid,
   output logic                 frame_err
);
   generate
      if (DIV_W < 1) begin : g_bad_div
         $error("DIV_W must be at least 1");
      end
      if (DATA_BITS < 2) begin : g_bad_bits
         $error("DATA_BITS must be at least 2");
      end
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("OVS must be even and at least 4");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic      line;
   logic      tick;
   rx_state_e state;

   rx_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst   (rst),
      .d_in  (rx_in),
      .d_out (line)
   );

   rx_baud_tick #(.DIV_W(DIV_W)) u_tick (
      .clk     (clk),
      .rst     (rst),
      .divisor (divisor),
      .tick    (tick)
   );

   rx_frame_sampler #(
      .DATA_BITS (DATA_BITS),
      .OVS       (OVS),
      .LSB_FIRST (LSB_FIRST)
   ) u_sampler (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick),
      .line    (line),
      .state_o (state),
      .data_o  (rx_data),
      .valid_o (rx_valid),
      .err_o   (frame_err)
   );
endmodule

// File: rtl/uart_rx_x8_chk.sv
module uart_rx_x8_chk
   import uart_rx_x8_pkg::*;
#(
   parameter int DIV_W     = 12,
   parameter int DATA_BITS = 8
) (
   input logic                 clk,
   input logic                 rst,
   input logic [DIV_W-1:0]     divisor,
   input logic                 tick,
   input rx_state_e            state,
   input logic [DATA_BITS-1:0] rx_data,
   input logic                 rx_valid,
   input logic                 frame_err
);
   // R1
   tick_every_clk_chk: assert property (@(posedge clk) disable iff (rst)
      (divisor == '0) |-> tick);

   // R1
   tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
      (tick && divisor != '0 && $stable(divisor)) |=> !tick);

   // R2
   hunt_waits_tick_chk: assert property (@(posedge clk) disable iff (rst)
      (state == ST_HUNT && !tick) |=> state == ST_HUNT);

   // R6
   outputs_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !rx_valid |-> ($stable(frame_err) && $stable(rx_data)));

   // R7
   valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      rx_valid |=> !rx_valid);

   // R8
   valid_in_hunt_chk: assert property (@(posedge clk) disable iff (rst)
      rx_valid |-> state == ST_HUNT);

   // R9
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (!rx_valid && !frame_err && rx_data == '0 && state == ST_HUNT));
endmodule

bind uart_rx_x8 uart_rx_x8_chk #(.DIV_W(DIV_W), .DATA_BITS(DATA_BITS)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .divisor   (divisor),
   .tick      (tick),
   .state     (state),
   .rx_data   (rx_data),
   .rx_valid  (rx_valid),
   .frame_err (frame_err)
);

// File: tb/uart_rx_x8_tb.sv
module uart_rx_x8_tb;
   localparam int CLK_NS = 20;

   typedef struct packed {
      logic [7:0]  d;
      logic        e;
      logic        lat;
      logic [31:0] t;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [11:0] divisor = '0;
   logic        rx_in = 1'b1;
   logic [7:0]  rx_data;
   logic        rx_valid;
   logic        frame_err;

   int unsigned n_cmp = 0;
   int unsigned n_bad = 0;
   logic [31:0] edge_cnt = '0;
   logic        prev_valid = 1'b0;
   exp_t        q[$];

   always #(CLK_NS/2) clk = ~clk;
   always @(posedge clk) edge_cnt <= edge_cnt + 1;

   uart_rx_x8 u_dut (
      .clk       (clk),
      .rst       (rst),
      .divisor   (divisor),
      .rx_in     (rx_in),
      .rx_data   (rx_data),
      .rx_valid  (rx_valid),
      .frame_err (frame_err)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // one sample value held for per clocks; called at a negedge
   task automatic samp(input logic v, input int per);
      for (int k = 0; k < per; k++) begin
         rx_in = v;
         @(negedge clk);
      end
   endtask

   // frame: window 0 start, 1..8 data, 9 stop; gl_* inverts one sample
   task automatic send_frame(input logic [7:0] d, input logic stop_v, input int stop_len,
                             input int per, input int gl_bit, input int gl_pos,
                             input logic lat, input logic expect_out);
      exp_t it;
      it.d = d; it.e = ~stop_v; it.lat = lat; it.t = edge_cnt;
      if (expect_out) q.push_back(it);
      for (int b = 0; b < 10; b++) begin
         logic v;
         int   len;
         v   = (b == 0) ? 1'b0 : (b == 9) ? stop_v : d[b-1];
         len = (b == 9) ? stop_len : 8;
         for (int s = 1; s <= len; s++)
            samp((b == gl_bit && s == gl_pos) ? ~v : v, per);
      end
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         rx_in = 1'b1;
         @(negedge clk);
      end
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (!rst) begin
         if (rx_valid && prev_valid) begin
            n_cmp++; n_bad++;
            $display("FAIL R7: actual valid width >1 expected 1");
         end
         if (rx_valid) begin
            if (q.size() == 0) begin
               n_cmp++; n_bad++;
               $display("FAIL R3: actual unexpected byte %0h expected none", rx_data);
            end else begin
               exp_t it;
               it = q.pop_front();
               check("R5 data", {24'd0, rx_data}, {24'd0, it.d});
               check("R6 frame_err", {31'd0, frame_err}, {31'd0, it.e});
               if (it.lat) check("R1 latency", edge_cnt - it.t, 32'd80);
            end
         end
      end
      prev_valid <= rx_valid;
   end

   initial begin
      #(CLK_NS * 200000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R9 reset state
      check("R9 rx_valid", {31'd0, rx_valid}, 32'd0);
      check("R9 frame_err", {31'd0, frame_err}, 32'd0);
      check("R9 rx_data", {24'd0, rx_data}, 32'd0);
      idle(10);

      // R1 R2 R5 plain frames, divisor 0, latency checked
      send_frame(8'hA5, 1'b1, 8, 1, -1, 0, 1'b1, 1'b1); idle(12);
      send_frame(8'h01, 1'b1, 8, 1, -1, 0, 1'b1, 1'b1); idle(12);
      send_frame(8'h80, 1'b1, 8, 1, -1, 0, 1'b1, 1'b1); idle(12);

      // R3 spikes: low 3 samples, then low 4 samples
      samp(1'b0, 1); samp(1'b0, 1); samp(1'b0, 1); idle(24);
      samp(1'b0, 1); samp(1'b0, 1); samp(1'b0, 1); samp(1'b0, 1); idle(24);
      check("R3 no byte pending", q.size(), 32'd0);

      // R4 start bit with one high sample at position 5
      send_frame(8'h3C, 1'b1, 8, 1, 0, 5, 1'b0, 1'b1); idle(12);
      // R4 start bit with high at position 8 (outside vote)
      send_frame(8'hC3, 1'b1, 8, 1, 0, 8, 1'b0, 1'b1); idle(12);

      // R5 data glitches: bit 1 (value 0) sample 4, bit 8 (value 1) sample 6
      send_frame(8'hF0, 1'b1, 8, 1, 1, 4, 1'b0, 1'b1); idle(12);
      send_frame(8'hF0, 1'b1, 8, 1, 8, 6, 1'b0, 1'b1); idle(12);

      // R6 framing error, byte still delivered, flag holds while idle
      send_frame(8'h5A, 1'b0, 8, 1, -1, 0, 1'b0, 1'b1); idle(40);
      check("R6 flag held", {31'd0, frame_err}, 32'd1);
      check("R6 data held", {24'd0, rx_data}, 32'h5A);
      send_frame(8'h66, 1'b1, 8, 1, -1, 0, 1'b0, 1'b1); idle(12);

      // R8 back-to-back with 6-sample stop bits
      send_frame(8'h12, 1'b1, 6, 1, -1, 0, 1'b1, 1'b1);
      send_frame(8'h34, 1'b1, 6, 1, -1, 0, 1'b1, 1'b1);
      send_frame(8'h56, 1'b1, 8, 1, -1, 0, 1'b1, 1'b1); idle(12);

      // R1 slower sample rates
      divisor = 12'd3; idle(10);
      send_frame(8'h9B, 1'b1, 8, 4, -1, 0, 1'b0, 1'b1); idle(40);
      send_frame(8'h47, 1'b0, 8, 4, -1, 0, 1'b0, 1'b1); idle(40);
      divisor = 12'd6; idle(10);
      send_frame(8'hE1, 1'b1, 8, 7, -1, 0, 1'b0, 1'b1); idle(60);

      // R9 reset mid-frame
      divisor = 12'd0; idle(4);
      for (int s = 0; s < 30; s++) samp(1'b0, 1);
      rst = 1'b1; rx_in = 1'b1;
      @(negedge clk); @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check("R9 mid-frame rx_valid", {31'd0, rx_valid}, 32'd0);
      check("R9 mid-frame frame_err", {31'd0, frame_err}, 32'd0);
      check("R9 mid-frame rx_data", {24'd0, rx_data}, 32'd0);
      idle(20);
      send_frame(8'h7E, 1'b1, 8, 1, -1, 0, 1'b1, 1'b1); idle(20);

      check("R7 all frames delivered", q.size(), 32'd0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule